// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds recent page translations for a 32-bit virtual address space with 4 KB pages. A virtual address splits into a 20-bit page number, `va[31:12]`, and a 12-bit offset, `va[11:0]`. A lookup compares the page number and the current address-space tag against every entry at once. In the same cycle it returns a hit flag, the physical address and a permission-fault flag.

After a miss, the translation fetched elsewhere is installed through the fill port. A fill goes into the first free slot, or otherwise replaces the entry chosen by a rotating pointer. Because entries carry an address-space tag, translations of several processes can coexist. The flush port clears either the whole cache or only the entries of one address space, for use on a context switch.

All updates (fill, flush and the dirty-bit set) take effect at the next rising clock edge. A lookup always reads the contents held before that edge.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a fill has been made.
- R2: `lk_hit` is high in the same cycle as the request exactly when `lk_req` is high and a valid entry holds both the page number `lk_va[31:12]` and the tag `lk_asid`; with `lk_req` low it is low.
- R3: An entry whose stored address-space tag differs from `lk_asid` never produces a hit, even if its page number matches.
- R4: On a hit `lk_pa` equals the stored 20-bit frame number joined above `lk_va[11:0]`; on a miss `lk_pa` is zero.
- R5: A fill that matches no valid entry writes the lowest-index invalid slot. If every slot is valid, it writes the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one on every fill, wrapping after the last slot.
- R6: Permission bits are bit0 read, bit1 write, bit2 execute and bit3 user-accessible. `lk_acc` encodes 0 as a read, 1 as a write, 2 as an execute and 3 as a read. On a hit, `lk_fault` is high when the bit for the access type is clear, or when `lk_user` is high and bit3 is clear. `lk_hit` stays high in that case, and `lk_fault` is never high without a hit.
- R7: `lk_dirty` reports the stored dirty bit of the entry that hits. A write hit without a fault sets that entry's dirty bit from the next cycle on.
- R8: A fill whose page number and tag match a valid entry overwrites that entry in place, so no two valid entries ever share a page number and tag.
- R9: `fl_all` clears the valid bit of every entry from the next cycle on.
- R10: `fl_asid_en` clears only the entries whose tag equals `fl_asid`; all other entries keep hitting.
- R11: When several operations fall in one cycle, the updates are applied in this order: the dirty set, then the fill, then the flush. A flush therefore also removes an entry filled in the same cycle if it qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 read) |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | 32 | Physical address, zero on a miss |
| lk_fault | output | 1 | Permission fault on a hit |
| lk_dirty | output | 1 | Stored dirty bit of the entry that hits |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_asid | input | 8 | Tag to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_perm | input | 4 | Permission bits to install (R6 layout) |
| fill_dirty | input | 1 | Initial dirty bit |
| fl_all | input | 1 | Invalidate every entry |
| fl_asid_en | input | 1 | Invalidate the entries of one tag |
| fl_asid | input | 8 | Tag for the selective flush |

## Verification
A lookup and an update can fall in the same cycle. The cases that matter are a write hit together with a fill of the same page, and a fill together with a full or selective flush that covers the new entry. The bench drives these pairs on purpose and also mixes them at random over a narrow range of page numbers and tags, so that collisions are frequent. A behavioural model applies the dirty set, the fill and the flush in the R11 order. Every cycle, its prediction of hit, address, fault and dirty bit is compared with the outputs. A same-cycle lookup must still see the contents from before the edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int ASID_W = 8;
    localparam int PERM_W = 4;

    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;
    localparam int PERM_USR = 3;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
        logic              dirty;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t        ents [N],
    input  logic [VPN_W-1:0]  key_vpn,
    input  logic [ASID_W-1:0] key_asid,
    output logic [N-1:0]      match
);
    // one comparator per slot, all evaluated in parallel
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ents[i].valid
                       && (ents[i].vpn  == key_vpn)
                       && (ents[i].asid == key_asid);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     dup,
    input  logic [IDX_W-1:0] rr,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] dup_idx;
    logic             any_free;
    logic             any_dup;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        // descending scan leaves the lowest free slot selected
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        dup_idx = '0;
        any_dup = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (dup[i]) begin
                dup_idx = IDX_W'(i);
                any_dup = 1'b1;
            end
        end
        if (any_dup)       idx = dup_idx;
        else if (any_free) idx = free_idx;
        else               idx = rr;
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic [1:0]        acc,
    input  logic              user,
    output logic              fault
);
    logic allowed;

    always_comb begin
        case (acc_e'(acc))
            ACC_STORE: allowed = perm[PERM_WR];
            ACC_FETCH: allowed = perm[PERM_EX];
            default:   allowed = perm[PERM_RD];
        endcase
        fault = !allowed || (user && !perm[PERM_USR]);
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [31:0]       lk_va,
    input  logic [7:0]        lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic [31:0]       lk_pa,
    output logic              lk_fault,
    output logic              lk_dirty,
    input  logic              fill_en,
    input  logic [19:0]       fill_vpn,
    input  logic [7:0]        fill_asid,
    input  logic [19:0]       fill_pfn,
    input  logic [3:0]        fill_perm,
    input  logic              fill_dirty,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [7:0]        fl_asid
);
    typedef struct packed {
        logic [IDX_W-1:0] rr;
    } ctl_t;

    tlb_entry_t ent_q [NUM_ENTRIES];
    tlb_entry_t ent_d [NUM_ENTRIES];
    ctl_t       ctl_q, ctl_d;

    logic [NUM_ENTRIES-1:0] lk_match;
    logic [NUM_ENTRIES-1:0] fill_match;
    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]       hit_idx;
    logic [IDX_W-1:0]       vic_idx;
    tlb_entry_t             hit_ent;
    logic                   perm_fault;

    // parallel lookup
    tlb_cam #(.N(NUM_ENTRIES)) u_lk_cam (
        .ents     (ent_q),
        .key_vpn  (lk_va[VA_W-1:OFF_W]),
        .key_asid (lk_asid),
        .match    (lk_match)
    );

    // duplicate search for the fill
    tlb_cam #(.N(NUM_ENTRIES)) u_fill_cam (
        .ents     (ent_q),
        .key_vpn  (fill_vpn),
        .key_asid (fill_asid),
        .match    (fill_match)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_valid
        assign valid_vec[i] = ent_q[i].valid;
    end

    tlb_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid (valid_vec),
        .dup   (fill_match),
        .rr    (ctl_q.rr),
        .idx   (vic_idx)
    );

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lk_match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_ent = ent_q[hit_idx];

    tlb_perm u_perm (
        .perm  (hit_ent.perm),
        .acc   (lk_acc),
        .user  (lk_user),
        .fault (perm_fault)
    );

    assign lk_hit   = lk_req && (|lk_match);
    assign lk_pa    = lk_hit ? {hit_ent.pfn, lk_va[OFF_W-1:0]} : '0;
    assign lk_fault = lk_hit && perm_fault;
    assign lk_dirty = lk_hit && hit_ent.dirty;

    // next state: dirty set, then fill, then flush
    always_comb begin
        ent_d = ent_q;
        ctl_d = ctl_q;

        if (lk_hit && (acc_e'(lk_acc) == ACC_STORE) && !perm_fault && !hit_ent.dirty) begin
            ent_d[hit_idx].dirty = 1'b1;
        end

        if (fill_en) begin
            ent_d[vic_idx].valid = 1'b1;
            ent_d[vic_idx].vpn   = fill_vpn;
            ent_d[vic_idx].asid  = fill_asid;
            ent_d[vic_idx].pfn   = fill_pfn;
            ent_d[vic_idx].perm  = fill_perm;
            ent_d[vic_idx].dirty = fill_dirty;
            ctl_d.rr = (ctl_q.rr == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ctl_q.rr + 1'b1;
        end

        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (fl_all || (fl_asid_en && (ent_d[i].asid == fl_asid))) begin
                ent_d[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
            ctl_q <= '0;
        end else begin
            ent_q <= ent_d;
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_req,
    input logic [31:0]  lk_va,
    input logic [7:0]   lk_asid,
    input logic [1:0]   lk_acc,
    input logic         lk_hit,
    input logic [31:0]  lk_pa,
    input logic         lk_fault,
    input logic         lk_dirty,
    input logic         fill_en,
    input logic         fl_all,
    input logic         fl_asid_en,
    input logic [N-1:0] lk_match,
    input logic [N-1:0] fill_match
);
    assert_fault_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !lk_hit);

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    assert_single_lookup_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_single_fill_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_match));

    assert_flush_all_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> !lk_hit);

    assert_dirty_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_fault && (lk_acc == 2'd1) && !fill_en && !fl_all && !fl_asid_en)
        |=> (!(lk_req && (lk_va[31:12] == $past(lk_va[31:12])) && (lk_asid == $past(lk_asid)))
             || lk_dirty));
endmodule

bind asid_tlb asid_tlb_checker #(.N(NUM_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_req     (lk_req),
    .lk_va      (lk_va),
    .lk_asid    (lk_asid),
    .lk_acc     (lk_acc),
    .lk_hit     (lk_hit),
    .lk_pa      (lk_pa),
    .lk_fault   (lk_fault),
    .lk_dirty   (lk_dirty),
    .fill_en    (fill_en),
    .fl_all     (fl_all),
    .fl_asid_en (fl_asid_en),
    .lk_match   (lk_match),
    .fill_match (fill_match)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [31:0] lk_va;
    logic [7:0]  lk_asid;
    logic [1:0]  lk_acc;
    logic        lk_user;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        lk_fault;
    logic        lk_dirty;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_pfn;
    logic [3:0]  fill_perm;
    logic        fill_dirty;
    logic        fl_all;
    logic        fl_asid_en;
    logic [7:0]  fl_asid;

    always #5 clk = ~clk;

    asid_tlb u_asid_tlb (.*);

    // behavioural model state
    bit          m_valid [N];
    bit [19:0]   m_vpn   [N];
    bit [7:0]    m_asid  [N];
    bit [19:0]   m_pfn   [N];
    bit [3:0]    m_perm  [N];
    bit          m_dirty [N];
    int          m_rr;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;
    string cur_tag = "R1";

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%h expected=%h at %0t", req, cur_tag, what, act, exp, $time);
        end
    endtask

    function automatic int model_find(input bit [19:0] vpn, input bit [7:0] asid);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic bit model_fault(input int h);
        bit ok;
        case (lk_acc)
            2'd1:    ok = m_perm[h][1];
            2'd2:    ok = m_perm[h][2];
            default: ok = m_perm[h][0];
        endcase
        return !ok || (lk_user && !m_perm[h][3]);
    endfunction

    // compare outputs, then advance the model across the next edge
    task automatic cyc();
        int h;
        bit e_hit;
        h = rst_n ? model_find(lk_va[31:12], lk_asid) : -1;
        e_hit = lk_req && (h >= 0);
        #1;
        chk("R2", "hit", {31'd0, lk_hit}, {31'd0, e_hit});
        chk("R4", "pa", lk_pa, e_hit ? {m_pfn[h], lk_va[11:0]} : 32'd0);
        chk("R6", "fault", {31'd0, lk_fault}, {31'd0, e_hit && model_fault(h)});
        chk("R7", "dirty", {31'd0, lk_dirty}, {31'd0, e_hit && m_dirty[h]});
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
            m_rr = 0;
        end else begin
            int f;
            int v;
            f = model_find(fill_vpn, fill_asid);
            if (e_hit && lk_acc == 2'd1 && !model_fault(h)) m_dirty[h] = 1;
            if (fill_en) begin
                if (f >= 0) v = f;
                else begin
                    v = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
                    if (v < 0) v = m_rr;
                end
                m_valid[v] = 1; m_vpn[v] = fill_vpn; m_asid[v] = fill_asid;
                m_pfn[v] = fill_pfn; m_perm[v] = fill_perm; m_dirty[v] = fill_dirty;
                m_rr = (m_rr + 1) % N;
            end
            for (int i = 0; i < N; i++)
                if (fl_all || (fl_asid_en && m_asid[i] == fl_asid)) m_valid[i] = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        lk_req = 0; lk_va = 0; lk_asid = 0; lk_acc = 0; lk_user = 0;
        fill_en = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0; fill_perm = 0; fill_dirty = 0;
        fl_all = 0; fl_asid_en = 0; fl_asid = 0;
    endtask

    task automatic look(input bit [19:0] vpn, input bit [7:0] asid, input bit [1:0] acc, input bit user);
        idle();
        lk_req = 1; lk_va = {vpn, 12'hA5C}; lk_asid = asid; lk_acc = acc; lk_user = user;
        cyc();
    endtask

    task automatic set_fill(input bit [19:0] vpn, input bit [7:0] asid, input bit [19:0] pfn,
                            input bit [3:0] perm, input bit dirty);
        fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn; fill_perm = perm; fill_dirty = dirty;
    endtask

    task automatic fill(input bit [19:0] vpn, input bit [7:0] asid, input bit [19:0] pfn,
                        input bit [3:0] perm, input bit dirty);
        idle();
        set_fill(vpn, asid, pfn, perm, dirty);
        cyc();
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        cur_tag = "R1";
        lk_req = 1; lk_va = 32'h0000_1000;
        cyc(); cyc();
        rst_n = 1;
        look(20'h00001, 8'd0, 0, 0);
        look(20'h00000, 8'd0, 0, 0);

        // R5: fill every slot, then evict by rotation
        cur_tag = "R5";
        for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 8'd1, 20'h8000 + 20'(i), 4'b1111, 0);
        for (int i = 0; i < N; i++) look(20'h100 + 20'(i), 8'd1, 0, 1);
        fill(20'h200, 8'd1, 20'hAAAAA, 4'b0001, 0);
        fill(20'h201, 8'd1, 20'hAAAAB, 4'b0001, 0);
        look(20'h100, 8'd1, 0, 0);
        look(20'h101, 8'd1, 0, 0);
        look(20'h102, 8'd1, 0, 0);
        look(20'h200, 8'd1, 0, 0);

        // R3: same page, other tag
        cur_tag = "R3";
        look(20'h105, 8'd2, 0, 0);
        fill(20'h105, 8'd2, 20'h77777, 4'b0011, 0);
        look(20'h105, 8'd2, 0, 0);
        look(20'h105, 8'd1, 0, 0);

        // R6: permission combinations
        cur_tag = "R6";
        for (int a = 0; a < 4; a++)
            for (int u = 0; u < 2; u++) begin
                look(20'h200, 8'd1, 2'(a), u[0]);
                look(20'h105, 8'd2, 2'(a), u[0]);
                look(20'h106, 8'd1, 2'(a), u[0]);
            end

        // R7: write hits set the dirty bit, faulting writes do not
        cur_tag = "R7";
        look(20'h105, 8'd2, 1, 0);
        look(20'h105, 8'd2, 0, 0);
        look(20'h200, 8'd1, 1, 0);
        look(20'h200, 8'd1, 0, 0);

        // R8: refill existing translation in place
        cur_tag = "R8";
        fill(20'h105, 8'd2, 20'h12345, 4'b0101, 0);
        look(20'h105, 8'd2, 2, 0);
        fill(20'h105, 8'd2, 20'h54321, 4'b1111, 1);
        look(20'h105, 8'd2, 0, 1);

        // R10: selective flush
        cur_tag = "R10";
        idle(); fl_asid_en = 1; fl_asid = 8'd2; cyc();
        look(20'h105, 8'd2, 0, 0);
        look(20'h105, 8'd1, 0, 0);
        look(20'h10F, 8'd1, 0, 0);

        // R11: same-cycle combinations
        cur_tag = "R11";
        idle(); lk_req = 1; lk_va = 32'h0030_0123; lk_asid = 8'd3;
        set_fill(20'h300, 8'd3, 20'h0BEEF, 4'b0111, 0); cyc();
        look(20'h300, 8'd3, 0, 0);
        idle(); lk_req = 1; lk_va = 32'h0030_0123; lk_asid = 8'd3; lk_acc = 1;
        set_fill(20'h300, 8'd3, 20'h0CAFE, 4'b0111, 0); cyc();
        look(20'h300, 8'd3, 0, 0);
        idle(); set_fill(20'h301, 8'd4, 20'h00F00, 4'b1111, 0);
        fl_asid_en = 1; fl_asid = 8'd4; cyc();
        look(20'h301, 8'd4, 0, 0);
        idle(); lk_req = 1; lk_va = 32'h0030_0000; lk_asid = 8'd3;
        set_fill(20'h302, 8'd5, 20'h00F01, 4'b1111, 0); fl_all = 1; cyc();

        // R9: everything gone after a full flush
        cur_tag = "R9";
        look(20'h300, 8'd3, 0, 0);
        look(20'h302, 8'd5, 0, 0);
        look(20'h10F, 8'd1, 0, 0);

        // random mix over a narrow key range
        cur_tag = "mix";
        for (int n = 0; n < 3000; n++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            lk_req = ($urandom_range(0, 3) != 0);
            lk_va = {20'($urandom_range(0, 23)), 12'($urandom)};
            lk_asid = 8'($urandom_range(0, 3));
            lk_acc = 2'($urandom_range(0, 3));
            lk_user = 1'($urandom_range(0, 1));
            if (r < 40) set_fill(20'($urandom_range(0, 23)), 8'($urandom_range(0, 3)),
                                 20'($urandom), 4'($urandom), 1'($urandom_range(0, 1)));
            if (r >= 95) fl_all = 1;
            else if (r >= 90) begin fl_asid_en = 1; fl_asid = 8'($urandom_range(0, 3)); end
            cyc();
        end

        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule